// File: doc/BRIEF.md
# Algebraic Right Shift with Carry

This block shifts a 32-bit word right by a variable count while copying the sign bit into the vacated upper positions. Alongside the result it produces a carry flag. The carry is set only when a negative source lost at least one 1 bit during the shift, which shows that the result was rounded toward minus infinity rather than being exact. An execution stage uses it for the two shift forms of an integer unit. In the register form the count comes from the low six bits of a second operand. In the immediate form the count comes from a five-bit field of the instruction.

The register form treats the sixth count bit as "shift by the full width or more". That case fills the whole result with the sign. Its carry is then set for any negative source, because a negative source is always nonzero. Every accepted operation updates the carry. On request the block also classifies the result against zero into a small condition code. All outputs are registered and appear one cycle after the strobe, together with a valid pulse.

Top module: `sra_carry_unit`

## Requirements
- R1: While reset is active and right after it, out_valid, out_word, out_carry and out_cond are all zero.
- R2: out_valid is high in exactly the cycle after each cycle in which strobe is high, and low otherwise. In a cycle with no strobe, out_word, out_carry and out_cond keep their values.
- R3: When use_imm is 1, the count is imm_amount (0 to 31) and reg_amount has no effect. out_word is src_word shifted right by that count, with copies of bit 31 filled in at the top.
- R4: When use_imm is 0 and reg_amount[5] is 0, the count is reg_amount[4:0], and the same sign-filling shift applies.
- R5: When use_imm is 0 and reg_amount[5] is 1, out_word is 32 copies of src_word[31], whatever reg_amount[4:0] holds.
- R6: For a count from 1 to 31, in either form, out_carry is 1 exactly when src_word[31] is 1 and at least one of the low count bits of src_word is 1.
- R7: For the full-width case of R5, out_carry equals src_word[31].
- R8: A count of zero returns src_word unchanged and clears out_carry, even for a negative source.
- R9: When record_en is 1 with the strobe, out_cond is 3'b100 for a negative result, 3'b010 for a positive nonzero result and 3'b001 for a zero result. When record_en is 0, out_cond is 3'b000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | Accept the operands in this cycle |
| src_word | input | 32 | Word to shift |
| reg_amount | input | 6 | Register-form count; bit 5 means full-width shift |
| imm_amount | input | 5 | Immediate-form count |
| use_imm | input | 1 | 1 selects imm_amount, 0 selects reg_amount |
| record_en | input | 1 | Produce the condition code for this operation |
| out_valid | output | 1 | Result registers were loaded in the previous cycle |
| out_word | output | 32 | Sign-filled shifted result |
| out_carry | output | 1 | Negative source lost one or more 1 bits |
| out_cond | output | 3 | {negative, positive, zero} of the result, or zero |

## Verification
The bench targets the edges of the lost-bit window. A count of 31 on 0x80000000 must give all ones with no carry, and a count of 1 on 0x80000001 must give a carry; a mask that is off by one bit gets one of these two wrong. Register counts with bit 5 set and nonzero low bits must still give a full sign fill. A design that ignores bit 5 would instead shift by the low bits only. A count of zero on an all-ones source must leave carry clear, which a mask built as "count plus one" bits would break. Immediate operations are driven with reg_amount set to all ones and the condition code is checked for all three classes, so a leaking select or a swapped code bit shows up in the word or condition compare.

// File: rtl/sra_carry_unit.sv
module sra_carry_unit #(
  parameter int WIDTH = 32,
  localparam int CNT_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [WIDTH-1:0] src_word,
  input  logic [CNT_W:0]   reg_amount,
  input  logic [CNT_W-1:0] imm_amount,
  input  logic             use_imm,
  input  logic             record_en,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_word,
  output logic             out_carry,
  output logic [2:0]       out_cond
);

  logic             sign;
  logic             wide;
  logic [CNT_W-1:0] count;
  logic [WIDTH-1:0] lost_mask;
  logic [WIDTH-1:0] shifted;
  logic             carry_n;
  logic [2:0]       cond_n;

  assign sign  = src_word[WIDTH-1];
  assign count = use_imm ? imm_amount : reg_amount[CNT_W-1:0];
  assign wide  = !use_imm && reg_amount[CNT_W];

  always_comb begin
    for (int i = 0; i < WIDTH; i++)
      lost_mask[i] = (i < int'(count));
  end

  assign shifted = wide ? {WIDTH{sign}} : WIDTH'($signed(src_word) >>> count);
  assign carry_n = sign & (wide ? (|src_word) : (|(src_word & lost_mask)));
  assign cond_n  = record_en ? {shifted[WIDTH-1], !shifted[WIDTH-1] && (|shifted), ~|shifted}
                             : 3'b000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_carry <= 1'b0;
      out_cond  <= 3'b000;
    end else begin
      out_valid <= strobe;
      if (strobe) begin
        out_word  <= shifted;
        out_carry <= carry_n;
        out_cond  <= cond_n;
      end
    end
  end

endmodule

// File: rtl/sra_carry_chk.sv
module sra_carry_chk #(
  parameter int WIDTH = 32,
  localparam int CNT_W = $clog2(WIDTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             strobe,
  input logic [WIDTH-1:0] src_word,
  input logic [CNT_W:0]   reg_amount,
  input logic [CNT_W-1:0] imm_amount,
  input logic             use_imm,
  input logic             record_en,
  input logic             out_valid,
  input logic [WIDTH-1:0] out_word,
  input logic             out_carry,
  input logic [2:0]       out_cond
);

  p_valid_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> out_valid);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> !out_valid && $stable(out_word) && $stable(out_carry) && $stable(out_cond));

  p_imm_by_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && use_imm && imm_amount == CNT_W'(1) |=>
      out_word == {$past(src_word[WIDTH-1]), $past(src_word[WIDTH-1:1])});

  p_wide_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && !use_imm && reg_amount[CNT_W] |=>
      ($past(src_word[WIDTH-1]) ? (&out_word) : (~|out_word)));

  p_positive_no_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && !src_word[WIDTH-1] |=> !out_carry);

  p_wide_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && !use_imm && reg_amount[CNT_W] |=> out_carry == $past(src_word[WIDTH-1]));

  p_zero_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && use_imm && imm_amount == '0 |=> out_word == $past(src_word) && !out_carry);

  p_cond_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_cond));

  p_cond_recorded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && record_en |=> $countones(out_cond) == 1);

  p_cond_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && !record_en |=> out_cond == 3'b000);

endmodule

bind sra_carry_unit sra_carry_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/test_sra_carry_unit.sv
`timescale 1ns/1ps
module test_sra_carry_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 1'b0;
  logic [31:0] src_word = '0;
  logic [5:0]  reg_amount = '0;
  logic [4:0]  imm_amount = '0;
  logic        use_imm = 1'b0;
  logic        record_en = 1'b0;
  logic        out_valid;
  logic [31:0] out_word;
  logic        out_carry;
  logic [2:0]  out_cond;

  always #2 clk = ~clk;

  sra_carry_unit i_sra_carry_unit (.*);

  typedef struct {
    logic [31:0] w;
    logic        c;
    logic [2:0]  k;
    logic        wide;
    logic        imm;
    int          n;
  } exp_t;

  exp_t        q[$];
  int          checks = 0;
  int          fails = 0;
  bit          done = 0;
  logic [31:0] last_word = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [31:0] s, input logic [5:0] ra, input logic [4:0] ia,
                                 input logic imm, input logic rec);
    exp_t e;
    int n;
    logic [63:0] ext;
    logic [63:0] lowbits;
    n = imm ? int'(ia) : int'(ra);
    ext = {{32{s[31]}}, s};
    if (n >= 32) e.w = {32{s[31]}};
    else e.w = 32'(ext >> n);
    lowbits = (n >= 32) ? {32'd0, s} : ({32'd0, s} & ((64'd1 << n) - 64'd1));
    e.c = s[31] && (lowbits != 0);
    if (!rec) e.k = 3'b000;
    else if (e.w[31]) e.k = 3'b100;
    else if (e.w != 0) e.k = 3'b010;
    else e.k = 3'b001;
    e.wide = (n >= 32);
    e.imm = imm;
    e.n = n;
    return e;
  endfunction

  task automatic drive(input logic [31:0] s, input logic [5:0] ra, input logic [4:0] ia,
                       input logic imm, input logic rec);
    @(negedge clk);
    src_word = s; reg_amount = ra; imm_amount = ia; use_imm = imm; record_en = rec;
    strobe = 1'b1;
    q.push_back(model(s, ra, ia, imm, rec));
  endtask

  task automatic idle(input int cycles);
    @(negedge clk);
    strobe = 1'b0;
    src_word = 32'hDEAD_BEEF; reg_amount = 6'h3F;
    repeat (cycles) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R2", {31'd0, out_valid}, 32'd0);
      end else begin
        exp_t e;
        string wreq;
        string creq;
        e = q.pop_front();
        wreq = e.wide ? "R5" : (e.imm ? "R3" : "R4");
        creq = e.wide ? "R7" : ((e.n == 0) ? "R8" : "R6");
        check(out_word === e.w, wreq, out_word, e.w);
        check(out_carry === e.c, creq, {31'd0, out_carry}, {31'd0, e.c});
        check(out_cond === e.k, "R9", {29'd0, out_cond}, {29'd0, e.k});
        last_word = out_word;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs are cleared while reset is held
    check(out_valid === 1'b0, "R1", {31'd0, out_valid}, 32'd0);
    check(out_word === 32'd0, "R1", out_word, 32'd0);
    check(out_carry === 1'b0, "R1", {31'd0, out_carry}, 32'd0);
    check(out_cond === 3'b000, "R1", {29'd0, out_cond}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R1", {31'd0, out_valid}, 32'd0);

    // R6 window edges
    drive(32'hF000_00F0, 6'd0, 5'd4, 1'b1, 1'b0);
    drive(32'h8000_0001, 6'd0, 5'd1, 1'b1, 1'b0);
    drive(32'h8000_0000, 6'd31, 5'd0, 1'b0, 1'b0);
    drive(32'h8000_0001, 6'd31, 5'd0, 1'b0, 1'b0);
    drive(32'h7FFF_FFFF, 6'd8, 5'd0, 1'b0, 1'b0);
    // R5 / R7: bit 5 set with nonzero low bits
    drive(32'h8000_0000, 6'd40, 5'd0, 1'b0, 1'b1);
    drive(32'h0000_1234, 6'd33, 5'd0, 1'b0, 1'b1);
    drive(32'h0000_0000, 6'd63, 5'd0, 1'b0, 1'b1);
    // R3: reg_amount ignored in immediate form
    drive(32'hC000_0003, 6'h3F, 5'd2, 1'b1, 1'b0);
    // R8: zero counts in both forms
    drive(32'hFFFF_FFFF, 6'h3F, 5'd0, 1'b1, 1'b1);
    drive(32'hFFFF_FFFF, 6'd0, 5'd7, 1'b0, 1'b0);
    // R9: the three classes
    drive(32'h0000_0100, 6'd4, 5'd0, 1'b0, 1'b1);
    drive(32'h0000_0001, 6'd0, 5'd3, 1'b1, 1'b1);
    drive(32'h9000_0000, 6'd0, 5'd3, 1'b1, 1'b1);

    // R2: no strobe means no valid and held outputs
    idle(4);
    check(out_valid === 1'b0, "R2", {31'd0, out_valid}, 32'd0);
    check(out_word === last_word, "R2", out_word, last_word);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] s;
      s = $urandom;
      if (i % 3 == 0) s[31] = 1'b1;
      drive(s, 6'($urandom), 5'($urandom), 1'($urandom), 1'($urandom));
      if (i % 17 == 0) idle(1);
    end
    idle(3);
    check(q.size() == 0, "R2", q.size(), 32'd0);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule